// File: doc/BRIEF.md
# T1 Timeslot to TDM Backplane Mapper

This block carries the 24 byte-wide payload timeslots of a T1 frame across a 32-channel serial TDM backplane. The backplane frame repeats at 8 kHz on a 4.096 MHz bit clock. On the transmit side it counts bit-clock cycles from the frame pulse. Ahead of each backplane channel that carries payload, it asks the user logic for the byte of the matching T1 timeslot, then shifts that byte out MSB first. In channels that carry nothing, the serial output is held quiet and its output-enable is low, so an external buffer can tri-state the line. On the receive side it follows an external frame pulse, samples each bit at its centre and hands the assembled byte over with its T1 timeslot number.

A static mode input selects one of two slot layouts. The spaced layout leaves every fourth channel idle. The grouped layout packs the 24 timeslots into the first 24 channels. The transmit side either follows an incoming frame pulse or runs freely and produces its own frame pulse. The receive side always follows its own pulse input.

Top module: `t1_tdm_mapper`

## Requirements
- R1: A frame is 512 bit-clock cycles long: 32 channels of 8 bits, each bit spanning two consecutive cycles, MSB first. When an active-low frame pulse is sampled on a rising edge, the following cycle is counter position 0, which is the first half of bit 7 of channel 0. Channel c occupies positions 16c to 16c+15.
- R2: With `mode_sel` = 0 (spaced), channels 0, 4, 8, ..., 28 are idle. Channel c otherwise carries T1 timeslot 3*(c/4) + (c mod 4), so timeslots 1 to 24 rise with the channel number.
- R3: With `mode_sel` = 1 (grouped), channel c for c < 24 carries timeslot c+1, and channels 24 to 31 are idle.
- R4: For the whole of an idle channel, `tx_sdo_oe` is 0 and `tx_sdo` is 0. For a mapped channel, `tx_sdo_oe` is 1.
- R5: `tx_rd` is high, combinationally, in the last cycle before a mapped channel begins, with `tx_rd_slot` = its timeslot (1 to 24). The byte on `tx_byte` in that cycle is the one sent. At all other times `tx_rd` = 0 and `tx_rd_slot` = 0.
- R6: `rx_sdi` is sampled on the rising edge that ends the first cycle of each bit. In the cycle after the sample of bit 0 of a mapped channel, `rx_valid` is high for exactly one cycle, with `rx_slot` = the timeslot and `rx_byte` = the 8 samples, first sample in bit 7. Idle channels give no strobe.
- R7: Each side takes `mode_sel` only on the edge where its counter restarts at position 0. A change in mid-frame has no effect until then.
- R8: With `tx_master` = 1, the transmit counter ignores `tx_fp_in_n` and wraps every 512 cycles. `tx_fp_out_n` is low exactly in the cycles at position 511. With `tx_master` = 0, `tx_fp_out_n` stays 1.
- R9: The receive counter always follows `rx_fp_n`, whatever `tx_master` is. A pulse in mid-frame restarts the frame at position 0.
- R10: While `rst_n` is low, both counters are at position 0, the mode is spaced, `tx_sdo_oe`, `tx_sdo` and `rx_valid` are 0, and `tx_fp_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_bclk | input | 1 | Transmit bit clock (4.096 MHz) |
| rx_bclk | input | 1 | Receive bit clock (4.096 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Slot layout: 0 spaced, 1 grouped |
| tx_master | input | 1 | 1: transmit side runs freely and drives its own frame pulse |
| tx_fp_in_n | input | 1 | Transmit frame pulse input, active low, used when tx_master = 0 |
| tx_fp_out_n | output | 1 | Generated transmit frame pulse, active low |
| tx_rd | output | 1 | Fetch request for the next channel's byte |
| tx_rd_slot | output | 5 | T1 timeslot requested (1 to 24) |
| tx_byte | input | 8 | Byte for the requested timeslot |
| tx_sdo | output | 1 | Serial transmit data |
| tx_sdo_oe | output | 1 | Output enable for tx_sdo, low in idle channels |
| rx_fp_n | input | 1 | Receive frame pulse, active low |
| rx_sdi | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_slot | output | 5 | T1 timeslot of the received byte |
| rx_byte | output | 8 | Received byte |

## Verification
Random payload bytes are sent and received over whole frames in both layouts. Every position is compared, so a channel wrongly placed, skipped or doubled in one layout shows up even when the other layout is right. The mode input is flipped in mid-frame, which separates a mode taken only at the frame restart from one taken at once. Frame pulses arrive in the middle of a channel on transmit and at a channel edge on receive; these show whether each counter restarts from its own pulse. In free-running transmit mode, random low pulses are put on the frame-pulse input; the check is that the period and the generated pulse do not move.

// File: rtl/t1map_pkg.sv
package t1map_pkg;
  localparam int unsigned NCH       = 32;          // backplane channels per frame
  localparam int unsigned NSLOT     = 24;          // T1 payload timeslots
  localparam int unsigned BW        = 8;           // bits per channel
  localparam int unsigned CPB       = 2;           // bit-clock cycles per data bit
  localparam int unsigned GRP       = 4;           // spaced layout: one idle channel per group
  localparam int unsigned CH_LEN    = BW * CPB;
  localparam int unsigned FRAME_LEN = NCH * CH_LEN;
  localparam int unsigned CHW       = $clog2(NCH);
  localparam int unsigned SW        = $clog2(NSLOT + 1);
  localparam int unsigned CW        = $clog2(FRAME_LEN);
  localparam int unsigned CPW       = $clog2(CH_LEN);
  localparam int unsigned BIW       = $clog2(BW);

  typedef enum logic {MAP_SPACED = 1'b0, MAP_GROUPED = 1'b1} map_mode_e;

  // Timeslot (1..NSLOT) carried by a channel, 0 when the channel is idle.
  function automatic logic [SW-1:0] slot_of(input logic [CHW-1:0] ch, input map_mode_e m);
    int unsigned c;
    int unsigned s;
    c = 32'(ch);
    if (m == MAP_GROUPED) s = (c < NSLOT) ? c + 1 : 0;
    else                  s = ((c % GRP) == 0) ? 0 : (c / GRP) * (GRP - 1) + (c % GRP);
    return SW'(s);
  endfunction

  function automatic logic [CHW-1:0] chan_of(input logic [CW-1:0] pos);
    return CHW'(32'(pos) / CH_LEN);
  endfunction

  function automatic logic [CPW-1:0] offs_of(input logic [CW-1:0] pos);
    return CPW'(32'(pos) % CH_LEN);
  endfunction
endpackage

// File: rtl/t1map_frame_cnt.sv
module t1map_frame_cnt #(
  parameter int unsigned LEN = t1map_pkg::FRAME_LEN,
  localparam int unsigned W  = $clog2(LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         free_run,
  input  logic         fp_n,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  logic at_last;
  logic fp_hit;

  always_comb begin
    at_last = (cnt == W'(LEN - 1));
    fp_hit  = !free_run && !fp_n;
    if (fp_hit || at_last) cnt_nxt = '0;
    else                   cnt_nxt = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt == $past(cnt) + W'(1)));

  // R9
  fp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && !fp_n) |=> (cnt == '0));
endmodule

// File: rtl/t1map_tx.sv
module t1map_tx
  import t1map_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [BW-1:0] byte_in,
  output logic          rd,
  output logic [SW-1:0] rd_slot,
  output logic          sdo,
  output logic          oe
);
  map_mode_e       mode_q, mode_eff;
  logic            frame_start;
  logic            ch_start;
  logic [SW-1:0]   nxt_slot;
  logic [BW-1:0]   byte_q;
  logic            oe_q;
  logic [BIW-1:0]  bit_idx;

  always_comb begin
    frame_start = (cnt_nxt == '0);
    mode_eff    = frame_start ? map_mode_e'(mode_in) : mode_q;
    ch_start    = (offs_of(cnt_nxt) == '0);
    nxt_slot    = slot_of(chan_of(cnt_nxt), mode_eff);
    rd          = ch_start && (nxt_slot != '0);
    rd_slot     = rd ? nxt_slot : '0;
    bit_idx     = BIW'(BW - 1 - 32'(offs_of(cnt)) / CPB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MAP_SPACED;
      byte_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (frame_start) mode_q <= mode_eff;
      if (ch_start) begin
        oe_q   <= rd;
        byte_q <= rd ? byte_in : '0;
      end
    end
  end

  assign sdo = byte_q[bit_idx];
  assign oe  = oe_q;

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !sdo);

  // R5
  rd_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> ((rd_slot != '0) && (rd_slot <= SW'(NSLOT))));

  // R5
  rd_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> oe);

  // R7
  tx_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (cnt == '0));
endmodule

// File: rtl/t1map_rx.sv
module t1map_rx
  import t1map_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          sdi,
  output logic          valid,
  output logic [SW-1:0] slot,
  output logic [BW-1:0] data
);
  map_mode_e       mode_q;
  logic [CPW-1:0]  in_ch;
  logic            sample;
  logic            last_bit;
  logic [SW-1:0]   cur_slot;
  logic            capture;
  logic [BW-2:0]   sh;
  logic            valid_q;
  logic [SW-1:0]   slot_q;
  logic [BW-1:0]   data_q;

  always_comb begin
    in_ch    = offs_of(cnt);
    sample   = (32'(in_ch) % CPB) == 0;
    last_bit = (in_ch == CPW'(CH_LEN - CPB));
    cur_slot = slot_of(chan_of(cnt), mode_q);
    capture  = sample && last_bit && (cur_slot != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MAP_SPACED;
      sh      <= '0;
      valid_q <= 1'b0;
      slot_q  <= '0;
      data_q  <= '0;
    end else begin
      if (cnt_nxt == '0) mode_q <= map_mode_e'(mode_in);
      if (sample) sh <= {sh[BW-3:0], sdi};
      valid_q <= capture;
      if (capture) begin
        slot_q <= cur_slot;
        data_q <= {sh, sdi};
      end
    end
  end

  assign valid = valid_q;
  assign slot  = slot_q;
  assign data  = data_q;

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R6
  strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((slot != '0) && (slot <= SW'(NSLOT))));

  // R6
  strobe_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((in_ch == CPW'(CH_LEN - CPB + 1)) || (cnt == '0)));

  // R7
  rx_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (cnt == '0));
endmodule

// File: rtl/t1_tdm_mapper.sv
module t1_tdm_mapper
  import t1map_pkg::*;
(
  input  logic          tx_bclk,
  input  logic          rx_bclk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          tx_master,
  input  logic          tx_fp_in_n,
  output logic          tx_fp_out_n,
  output logic          tx_rd,
  output logic [SW-1:0] tx_rd_slot,
  input  logic [BW-1:0] tx_byte,
  output logic          tx_sdo,
  output logic          tx_sdo_oe,
  input  logic          rx_fp_n,
  input  logic          rx_sdi,
  output logic          rx_valid,
  output logic [SW-1:0] rx_slot,
  output logic [BW-1:0] rx_byte
);
  logic [CW-1:0] tx_cnt, tx_cnt_nxt;
  logic [CW-1:0] rx_cnt, rx_cnt_nxt;

  t1map_frame_cnt #(.LEN(FRAME_LEN)) u_tx_cnt (
    .clk(tx_bclk), .rst_n(rst_n), .free_run(tx_master), .fp_n(tx_fp_in_n),
    .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt)
  );

  t1map_frame_cnt #(.LEN(FRAME_LEN)) u_rx_cnt (
    .clk(rx_bclk), .rst_n(rst_n), .free_run(1'b0), .fp_n(rx_fp_n),
    .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt)
  );

  assign tx_fp_out_n = !(tx_master && (tx_cnt == CW'(FRAME_LEN - 1)));

  t1map_tx u_tx (
    .clk(tx_bclk), .rst_n(rst_n), .mode_in(mode_sel),
    .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt), .byte_in(tx_byte),
    .rd(tx_rd), .rd_slot(tx_rd_slot), .sdo(tx_sdo), .oe(tx_sdo_oe)
  );

  t1map_rx u_rx (
    .clk(rx_bclk), .rst_n(rst_n), .mode_in(mode_sel),
    .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt), .sdi(rx_sdi),
    .valid(rx_valid), .slot(rx_slot), .data(rx_byte)
  );

  // R8
  fp_out_wrap_chk: assert property (@(posedge tx_bclk) disable iff (!rst_n)
    !tx_fp_out_n |=> (tx_cnt == '0));

  // R8
  fp_out_single_chk: assert property (@(posedge tx_bclk) disable iff (!rst_n)
    !tx_fp_out_n |=> tx_fp_out_n);
endmodule

// File: tb/t1_tdm_mapper_tb_top.sv
`timescale 1ns/1ps
module t1_tdm_mapper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       tx_master = 1'b0;
  logic       tx_fp_in_n = 1'b1;
  logic       tx_fp_out_n;
  logic       tx_rd;
  logic [4:0] tx_rd_slot;
  logic [7:0] tx_byte;
  logic       tx_sdo, tx_sdo_oe;
  logic       rx_fp_n = 1'b1;
  logic       rx_sdi = 1'b0;
  logic       rx_valid;
  logic [4:0] rx_slot;
  logic [7:0] rx_byte;

  logic [7:0] tx_pay [0:31];
  logic [7:0] rx_pay [0:31];

  int errors = 0, checks = 0;
  bit done = 0;
  int tk = 0, rk = 0, prk = 0;
  int tmode = 0, rmode = 0, prmode = 0;
  int tx_resync_at = -1, rx_resync_at = -1;
  bit exp_oe = 0;
  logic [7:0] exp_byte = 8'h00;

  always #5 clk = ~clk;

  assign tx_byte = tx_pay[tx_rd_slot];

  t1_tdm_mapper dut_i (
    .tx_bclk(clk), .rx_bclk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .tx_master(tx_master), .tx_fp_in_n(tx_fp_in_n), .tx_fp_out_n(tx_fp_out_n),
    .tx_rd(tx_rd), .tx_rd_slot(tx_rd_slot), .tx_byte(tx_byte),
    .tx_sdo(tx_sdo), .tx_sdo_oe(tx_sdo_oe), .rx_fp_n(rx_fp_n), .rx_sdi(rx_sdi),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_byte(rx_byte)
  );

  // Timeslot in a channel, found by walking the channels (0 = idle).
  function automatic int exp_slot(int ch, int m);
    int s;
    s = 0;
    if (m != 0) return (ch < 24) ? ch + 1 : 0;
    if (ch % 4 == 0) return 0;
    for (int c = 0; c <= ch; c++) if (c % 4 != 0) s++;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (tx pos %0d rx pos %0d)",
               req, what, act, exp, tk, rk);
    end
  endtask

  task automatic step();
    int ntk, nrk, s, me, bi;
    string tag;
    if (tx_master) tx_fp_in_n = ($urandom % 8) != 0;
    else           tx_fp_in_n = !(tk == 511 || tk == tx_resync_at);
    rx_fp_n = !(rk == 511 || rk == rx_resync_at);
    if (tk == 511) for (int i = 0; i < 32; i++) tx_pay[i] = 8'($urandom);
    if (rk == 511) for (int i = 0; i < 32; i++) rx_pay[i] = 8'($urandom);
    rx_sdi = rx_pay[rk / 16][7 - ((rk % 16) / 2)];
    #1;
    ntk = (!tx_master && !tx_fp_in_n) ? 0 : (tk + 1) % 512;
    me  = (ntk == 0) ? int'(mode_sel) : tmode;
    s   = (ntk % 16 == 0) ? exp_slot(ntk / 16, me) : 0;
    chk("R5", tx_rd, (s != 0), "tx_rd");
    chk("R5", tx_rd_slot, s, "tx_rd_slot");
    if (ntk % 16 == 0) begin
      exp_oe   = (s != 0);
      exp_byte = (s != 0) ? tx_pay[s] : 8'h00;
    end
    if (ntk == 0) tmode = me;
    if (tk == tx_resync_at) tx_resync_at = -1;
    if (rk == rx_resync_at) rx_resync_at = -1;
    tk = ntk;
    nrk = !rx_fp_n ? 0 : (rk + 1) % 512;
    prk = rk; prmode = rmode;
    if (nrk == 0) rmode = int'(mode_sel);
    rk = nrk;
    @(negedge clk);
    bi  = 7 - ((tk % 16) / 2);
    tag = (tmode != 0) ? "R1 R3" : "R1 R2";
    if (tmode != int'(mode_sel)) tag = {tag, " R7"};
    if (exp_oe) begin
      chk(tag, tx_sdo_oe, 1, "tx_sdo_oe");
      chk(tag, tx_sdo, exp_byte[bi], "tx_sdo");
    end else begin
      chk("R4", tx_sdo_oe, 0, "tx_sdo_oe idle");
      chk("R4", tx_sdo, 0, "tx_sdo idle");
    end
    chk("R8", tx_fp_out_n, !(tx_master && tk == 511), "tx_fp_out_n");
    s = exp_slot(prk / 16, prmode);
    chk("R6 R9", rx_valid, (prk % 16 == 14) && (s != 0), "rx_valid");
    if ((prk % 16 == 14) && (s != 0)) begin
      chk("R6", rx_slot, s, "rx_slot");
      chk("R6 R9", rx_byte, rx_pay[prk / 16], "rx_byte");
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      tx_pay[i] = 8'($urandom);
      rx_pay[i] = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", tx_sdo_oe, 0, "tx_sdo_oe in reset");
    chk("R10", tx_sdo, 0, "tx_sdo in reset");
    chk("R10", rx_valid, 0, "rx_valid in reset");
    chk("R10", tx_fp_out_n, 1, "tx_fp_out_n in reset");
    chk("R10", tx_rd, 0, "tx_rd in reset");
    rst_n = 1'b1;
    run(700);                       // spaced layout, R2
    mode_sel = 1'b1;                // mid-frame change, R7
    run(900);                       // grouped layout, R3
    tx_resync_at = 300;             // mid-channel restart, R9 on tx side
    rx_resync_at = 335;             // channel-edge restart, R9
    run(1200);
    mode_sel = 1'b0;
    run(1024);
    for (int i = 0; i < 4; i++) begin
      mode_sel = 1'($urandom);
      run(300 + int'($urandom % 700));
    end
    tx_master = 1'b1;               // free-running transmit, R8
    run(1536);
    mode_sel = ~mode_sel;
    rx_resync_at = 111;
    run(1024);
    done = 1;
    summary();
    $finish;
  end
endmodule